// File: doc/BRIEF.md
# Branch-Driven Context Sequencer

The sequencer decides which configuration context of a reconfigurable accelerator is active during a run. Before a run, a host fills a small context table through a write port. Each entry holds a settling delay, the context that follows when the branch resolves taken, the context that follows when it resolves not taken, and a flag that marks the entry as the last one of the function.

A start pulse carries the entry context and the host's return address. From then on a cycle counter measures how long the current context has been active. When the count reaches that context's delay, the sequencer samples the branch outcome from the combinational ALU array and moves to the selected context. It pulses a one-cycle capture strobe so that the operand-forwarding matrix loads the new routing. When an exit context expires, the sequencer pulses done, presents the latched return address, and goes back to idle.

Top module: `ctx_sequencer`

## Requirements
- R1: While reset is held, and at its release, busy, capture and done are 0, cur_ctx is 0 and ret_addr_out is 0.
- R2: A table write (cfg_we high) takes effect only while the sequencer is idle. A write issued while busy changes nothing that later runs observe.
- R3: A start pulse while idle with start_ctx below 6 makes, one cycle later, busy 1, cur_ctx equal to start_ctx and capture 1, and latches ret_addr_in.
- R4: A start pulse while busy, or with start_ctx of 6 or 7, has no effect on any output.
- R5: A context with delay D (4-bit field) stays current for exactly D cycles when D is 1 to 15. The counter begins at zero on every entry into a context.
- R6: In the last cycle of a non-exit context, branch_taken high selects that entry's taken-next index and low selects its not-taken index. The new context appears one cycle later. branch_taken in any other cycle has no effect.
- R7: capture is high for exactly one cycle on each entry into a context, in the first cycle that cur_ctx shows the new value. It is low at all other times.
- R8: When an exit context's delay expires, done is high for one cycle, busy drops in that same cycle, and ret_addr_out equals the address latched at start. branch_taken is ignored there.
- R9: A delay field of zero acts as a delay of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | 3 | Table entry written |
| cfg_delay | input | 4 | Settling delay of the entry |
| cfg_next_t | input | 3 | Next context when the branch is taken |
| cfg_next_nt | input | 3 | Next context when the branch is not taken |
| cfg_exit | input | 1 | Entry ends the function |
| start | input | 1 | Run request pulse |
| start_ctx | input | 3 | Entry context of the run |
| ret_addr_in | input | 32 | Host return address, latched at start |
| branch_taken | input | 1 | Branch outcome from the ALU array |
| busy | output | 1 | Run in progress |
| cur_ctx | output | 3 | Active context index |
| capture | output | 1 | One-cycle load strobe for the forwarding matrix |
| done | output | 1 | One-cycle completion pulse |
| ret_addr_out | output | 32 | Latched return address |

## Verification
Every output is registered. A start accepted at one clock edge therefore shows busy, cur_ctx and capture at the next sample. A context entered at edge k changes at edge k+max(D,1). The done pulse and busy dropping appear at that same edge when the context is an exit. The bench's model advances its state at each rising edge from the inputs it drove half a cycle earlier. It compares every output at each falling edge, so each result is checked in exactly the cycle it is due and never a cycle early or late.

// File: rtl/ctx_sequencer.sv
module ctx_sequencer #(
  parameter int NUM_CTX = 6,
  parameter int DLY_W   = 4,
  parameter int RET_W   = 32,
  parameter int IDX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_addr,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [IDX_W-1:0] cfg_next_t,
  input  logic [IDX_W-1:0] cfg_next_nt,
  input  logic             cfg_exit,
  input  logic             start,
  input  logic [IDX_W-1:0] start_ctx,
  input  logic [RET_W-1:0] ret_addr_in,
  input  logic             branch_taken,
  output logic             busy,
  output logic [IDX_W-1:0] cur_ctx,
  output logic             capture,
  output logic             done,
  output logic [RET_W-1:0] ret_addr_out
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W:0] LIMIT = NUM_CTX[IDX_W:0];

  logic [DLY_W-1:0] dly_q [DEPTH];
  logic [IDX_W-1:0] nt_q  [DEPTH];
  logic [IDX_W-1:0] nn_q  [DEPTH];
  logic [DEPTH-1:0] ex_q;
  logic [DLY_W-1:0] cnt;

  wire [DLY_W-1:0] cur_dly = dly_q[cur_ctx];
  wire [DLY_W-1:0] eff_m1  = (cur_dly == '0) ? '0 : cur_dly - 1'b1;
  wire             last    = busy && (cnt == eff_m1);
  wire             go      = !busy && start && ({1'b0, start_ctx} < LIMIT);
  wire             wr      = !busy && cfg_we && ({1'b0, cfg_addr} < LIMIT);
  wire [IDX_W-1:0] nxt     = branch_taken ? nt_q[cur_ctx] : nn_q[cur_ctx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        dly_q[i] <= '0;
        nt_q[i]  <= '0;
        nn_q[i]  <= '0;
      end
      ex_q <= '0;
    end else if (wr) begin
      dly_q[cfg_addr] <= cfg_delay;
      nt_q[cfg_addr]  <= cfg_next_t;
      nn_q[cfg_addr]  <= cfg_next_nt;
      ex_q[cfg_addr]  <= cfg_exit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      cur_ctx      <= '0;
      capture      <= 1'b0;
      done         <= 1'b0;
      cnt          <= '0;
      ret_addr_out <= '0;
    end else begin
      capture <= 1'b0;
      done    <= 1'b0;
      if (go) begin
        busy         <= 1'b1;
        cur_ctx      <= start_ctx;
        cnt          <= '0;
        capture      <= 1'b1;
        ret_addr_out <= ret_addr_in;
      end else if (last) begin
        if (ex_q[cur_ctx]) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cur_ctx <= nxt;
          cnt     <= '0;
          capture <= 1'b1;
        end
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CAPTURE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) capture |-> busy && cnt == '0); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && !capture); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> cnt <= eff_m1); // R5
  AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) busy && !last |=> busy && $stable(cur_ctx) && !capture); // R4
  AST_RET_HOLD: assert property (@(posedge clk) disable iff (!rst_n) busy && !capture |-> $stable(ret_addr_out)); // R3
endmodule

// File: tb/sim_ctx_sequencer.sv
module sim_ctx_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_exit = 1'b0, start = 1'b0, branch_taken = 1'b0;
  logic [2:0] cfg_addr = '0, cfg_next_t = '0, cfg_next_nt = '0, start_ctx = '0;
  logic [3:0] cfg_delay = '0;
  logic [31:0] ret_addr_in = '0;
  logic busy, capture, done;
  logic [2:0] cur_ctx;
  logic [31:0] ret_addr_out;

  int checks = 0, errors = 0, cyc = 0;
  bit started = 0;

  int m_dly[6], m_t[6], m_nt[6], m_ex[6];
  int m_busy = 0, m_ctx = 0, m_cnt = 0, m_cap = 0, m_done = 0;
  logic [31:0] m_ret = '0;
  int lfsr = 32'h1d;

  ctx_sequencer u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_delay(cfg_delay), .cfg_next_t(cfg_next_t), .cfg_next_nt(cfg_next_nt),
    .cfg_exit(cfg_exit), .start(start), .start_ctx(start_ctx), .ret_addr_in(ret_addr_in),
    .branch_taken(branch_taken), .busy(busy), .cur_ctx(cur_ctx), .capture(capture),
    .done(done), .ret_addr_out(ret_addr_out));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    started = 1;
    m_cap = 0;
    m_done = 0;
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin m_dly[i] = 0; m_t[i] = 0; m_nt[i] = 0; m_ex[i] = 0; end
      m_busy = 0; m_ctx = 0; m_cnt = 0; m_ret = '0;
    end else if (!m_busy) begin
      if (cfg_we && cfg_addr < 6) begin
        m_dly[cfg_addr] = cfg_delay; m_t[cfg_addr] = cfg_next_t;
        m_nt[cfg_addr] = cfg_next_nt; m_ex[cfg_addr] = cfg_exit;
      end
      if (start && start_ctx < 6) begin
        m_busy = 1; m_ctx = start_ctx; m_cnt = 0; m_cap = 1; m_ret = ret_addr_in;
      end
    end else begin
      if (m_cnt + 1 >= ((m_dly[m_ctx] == 0) ? 1 : m_dly[m_ctx])) begin
        if (m_ex[m_ctx] != 0) begin
          m_busy = 0; m_done = 1;
        end else begin
          m_ctx = branch_taken ? m_t[m_ctx] : m_nt[m_ctx];
          m_cnt = 0; m_cap = 1;
        end
      end else m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk(busy == m_busy[0], "R3/R5/R8 busy", busy, m_busy);
      chk(cur_ctx == m_ctx[2:0], "R5/R6 cur_ctx", cur_ctx, m_ctx);
      chk(capture == m_cap[0], "R7 capture", capture, m_cap);
      chk(done == m_done[0], "R8 done", done, m_done);
      chk(ret_addr_out == m_ret, "R3/R8 ret_addr_out", ret_addr_out, m_ret);
    end
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
    branch_taken <= lfsr[0];
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input int a, input int d, input int t, input int nt, input bit ex);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a[2:0]; cfg_delay = d[3:0];
    cfg_next_t = t[2:0]; cfg_next_nt = nt[2:0]; cfg_exit = ex;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic go(input int c, input logic [31:0] ra);
    @(negedge clk);
    start = 1; start_ctx = c[2:0]; ret_addr_in = ra;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !capture && !done && cur_ctx == 0 && ret_addr_out == 0, "R1 reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && cur_ctx == 0, "R1 after release", busy, 0);
    wr(0, 2, 1, 2, 0);
    wr(1, 0, 3, 3, 0);
    wr(2, 3, 0, 3, 0);
    wr(3, 1, 0, 0, 1);
    wr(4, 15, 5, 5, 0);
    wr(5, 4, 0, 0, 1);
    go(0, 32'h0000_1234);
    chk(busy && cur_ctx == 0, "R3 entry", cur_ctx, 0);
    start = 1; start_ctx = 4;
    cfg_we = 1; cfg_addr = 3; cfg_exit = 0; cfg_delay = 9;
    @(negedge clk);
    chk(cur_ctx == 0 || capture, "R4 start ignored while busy", cur_ctx, 0);
    start = 0; cfg_we = 0;
    wait_idle();
    chk(ret_addr_out == 32'h0000_1234, "R8 return address", ret_addr_out, 32'h1234);
    go(7, 32'hdead_beef);
    chk(!busy && ret_addr_out == 32'h0000_1234, "R4 out-of-range start", busy, 0);
    go(1, 32'h0000_00a0);
    chk(busy && capture && cur_ctx == 1, "R9 zero-delay entry", cur_ctx, 1);
    @(negedge clk);
    chk(cur_ctx == 3 && capture, "R9 one cycle then switch", cur_ctx, 3);
    @(negedge clk);
    chk(done && !busy, "R2 exit entry unchanged by busy write", done, 1);
    wait_idle();
    go(4, 32'h0000_0444);
    repeat (14) begin
      @(negedge clk);
      chk(cur_ctx == 4 && !capture, "R5 delay fifteen hold", cur_ctx, 4);
    end
    @(negedge clk);
    chk(cur_ctx == 5 && capture, "R6 switch after fifteen", cur_ctx, 5);
    wait_idle();
    wr(3, 1, 0, 0, 0);
    wr(0, 1, 2, 2, 0);
    wr(2, 2, 5, 0, 0);
    for (int k = 0; k < 6; k++) begin
      go(k % 3, 32'h100 + k);
      wait_idle();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule